// File: doc/BRIEF.md
# Banked Gamma Lookup Stage

This block applies per-channel gamma correction to a stream of RGB pixels with 10-bit channels. A lookup table of packed three-channel words is loaded through a small register bus. The pixel path looks up red, green and blue on their own, each from its own channel field of the table word. While the table is switched off, pixels leave the block untouched.

The table can be split into equal banks. All banks share one address window, and a bank-select register chooses which bank that window writes and reads. A compression mode can also be switched on. In this mode each odd table entry holds an increment over the even entry just below it. The pixel path adds the two to rebuild the absolute value, and the sum saturates at full scale.

The pixel path takes two cycles. The valid bit travels with the data. The register bus returns read data on the cycle after a read strobe.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset, pix_valid_o is low, and the control, size and bank registers all read back as zero.
- R2: The control register at offset 0x020 holds the table enable in bit 0 and the delta mode in bit 1. Its other bits read as zero.
- R3: The size register at offset 0x030 keeps written bits [28:16] (horizontal) and [12:0] (vertical). All other bits read as zero.
- R4: With several banks, the bank register at offset 0x100 keeps as many of bits [1:0] as the bank count needs. A write to offset 0x700+4*i, for i below the bank size, stores into global entry bank*BANK_ENTRIES+i.
- R5: A table word carries red in bits [29:20], green in [19:10] and blue in [9:0]. Reading 0x700+4*i returns the stored 30-bit word of the selected bank, with bits [31:30] zero.
- R6: With the table enabled and delta mode off, each output channel is the field of that channel in table entry (channel >> (10 - log2(TOTAL_ENTRIES))). The high index bits select the bank.
- R7: With the table enabled and delta mode on, an even index returns its own field. An odd index returns the field of entry index-1 plus its own field, saturated to 1023.
- R8: With the table disabled, every channel passes through unchanged, whatever the delta bit says.
- R9: pix_valid_o equals pix_valid_i two clock cycles earlier, and pix_data_o belongs to that same input.
- R10: reg_rdata shows the addressed value on the cycle after reg_rd. Offsets that map to nothing, including word offsets past the end of the window, read as zero and ignore writes.
- R11: With a single bank, the bank register ignores writes and reads as zero, and the window reaches every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | 30 | Input pixel, red [29:20], green [19:10], blue [9:0] |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 30 | Corrected pixel, same layout |

## Verification
A register read is due on the cycle after its strobe. The bench raises reg_rd at one falling edge and samples reg_rdata at the next falling edge. A pixel result is due two rising edges after it is driven. For each pixel the bench computes the expected word at the moment it drives it, places it in a two-deep history, and compares it with the output two falling edges later. Invalid cycles are also checked, so that no valid appears early or late. Two instances run on the same stimulus, one with four banks and one with a single bank. Writes that fall outside the smaller window therefore also test that unmapped accesses are ignored.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int CH_W   = 10;
    localparam int NCH    = 3;
    localparam int WORD_W = NCH * CH_W;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int DIM_W  = 13;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SIZE = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_BANK = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_LUT  = 12'h700;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        logic delta;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [DIM_W-1:0] h;
        logic [DIM_W-1:0] v;
    } dim_t;

    // Channel c of a packed word: c = 0 is red at the top.
    function automatic chan_t word_chan(input logic [WORD_W-1:0] w, input int c);
        return w[WORD_W-1-c*CH_W -: CH_W];
    endfunction

    function automatic chan_t sat_add(input chan_t a, input chan_t b);
        logic [CH_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CH_W] ? {CH_W{1'b1}} : s[CH_W-1:0];
    endfunction

endpackage

// File: rtl/gamma_lut_mem.sv
module gamma_lut_mem
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            bus_idx,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [WORD_W-1:0]           bus_word,
    input  logic [NCH-1:0][IDX_W-1:0]   look_idx,
    output logic [NCH-1:0][WORD_W-1:0]  even_word,
    output logic [NCH-1:0][WORD_W-1:0]  own_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[bus_idx] <= wr_data;
        end
    end

    assign bus_word = mem[bus_idx];

    for (genvar c = 0; c < NCH; c++) begin : g_port
        assign own_word[c]  = mem[look_idx[c]];
        assign even_word[c] = mem[{look_idx[c][IDX_W-1:1], 1'b0}];
    end

    // A bus write lands in the entry it addressed.
    assert_lut_store_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(bus_idx)] == $past(wr_data));

endmodule

// File: rtl/gamma_reg_if.sv
module gamma_reg_if
    import gamma_lut_pkg::*;
#(
    parameter int TOTAL_ENTRIES = 512,
    parameter int BANK_ENTRIES  = 512,
    localparam int NUM_BANKS = TOTAL_ENTRIES / BANK_ENTRIES,
    localparam int IDX_W     = $clog2(TOTAL_ENTRIES),
    localparam int ENT_W     = $clog2(BANK_ENTRIES),
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output ctrl_t             ctrl_o,
    output logic              lut_we_o,
    output logic [IDX_W-1:0]  lut_idx_o,
    output logic [WORD_W-1:0] lut_wdata_o,
    input  logic [WORD_W-1:0] lut_word_i
);

    ctrl_t             ctrl_q;
    dim_t              dim_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] lut_off;
    logic              lut_hit;
    logic [ENT_W-1:0]  ent;
    logic              unused_wbits;

    assign lut_off = DATA_W'(reg_addr) - DATA_W'(OFS_LUT);
    assign lut_hit = (DATA_W'(reg_addr) >= DATA_W'(OFS_LUT))
                  && (lut_off < DATA_W'(4 * BANK_ENTRIES))
                  && (reg_addr[1:0] == 2'b00);
    assign ent     = lut_off[ENT_W+1:2];

    assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[15:13]};

    generate
        if (NUM_BANKS > 1) begin : g_multi
            logic [BANK_W-1:0] bank_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q <= '0;
                end else if (reg_wr && reg_addr == OFS_BANK) begin
                    bank_q <= reg_wdata[BANK_W-1:0];
                end
            end
            assign lut_idx_o = {bank_q, ent};
            assign bank_rd   = {{(DATA_W-BANK_W){1'b0}}, bank_q};
        end else begin : g_single
            assign lut_idx_o = ent;
            assign bank_rd   = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dim_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_CTRL) begin
                ctrl_q <= '{delta: reg_wdata[1], enable: reg_wdata[0]};
            end
            if (reg_addr == OFS_SIZE) begin
                dim_q <= '{h: reg_wdata[28:16], v: reg_wdata[12:0]};
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (lut_hit) begin
            rd_next = {{(DATA_W-WORD_W){1'b0}}, lut_word_i};
        end else begin
            case (reg_addr)
                OFS_CTRL: rd_next = DATA_W'({ctrl_q.delta, ctrl_q.enable});
                OFS_SIZE: rd_next = {3'b000, dim_q.h, 3'b000, dim_q.v};
                OFS_BANK: rd_next = bank_rd;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rd_next;
        end
    end

    assign reg_rdata   = rdata_q;
    assign ctrl_o      = ctrl_q;
    assign lut_we_o    = reg_wr && lut_hit;
    assign lut_wdata_o = reg_wdata[WORD_W-1:0];

endmodule

// File: rtl/gamma_chan_pipe.sv
module gamma_chan_pipe
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  chan_t            pix_i,
    output logic [IDX_W-1:0] look_idx_o,
    input  chan_t            even_i,
    input  chan_t            own_i,
    output chan_t            pix_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  odd;
        chan_t pix;
        chan_t even;
        chan_t own;
    } stage_t;

    stage_t s1_q;
    chan_t  res;

    assign look_idx_o = pix_i[CH_W-1 -: IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q <= '{ctrl: ctrl_i, odd: look_idx_o[0], pix: pix_i,
                      even: even_i, own: own_i};
        end
    end

    always_comb begin
        res = s1_q.pix;
        if (s1_q.ctrl.enable) begin
            res = (s1_q.ctrl.delta && s1_q.odd) ? sat_add(s1_q.even, s1_q.own)
                                                : s1_q.own;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o <= '0;
        end else begin
            pix_o <= res;
        end
    end

    // A rebuilt odd entry never falls below its even base.
    assert_delta_floor_R7: assert property (@(posedge clk) disable iff (rst)
        (s1_q.ctrl.enable && s1_q.ctrl.delta && s1_q.odd) |=> pix_o >= $past(s1_q.even));

endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
    import gamma_lut_pkg::*;
#(
    parameter int TOTAL_ENTRIES = 512,
    parameter int BANK_ENTRIES  = 512,
    localparam int IDX_W = $clog2(TOTAL_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pix_valid_i,
    input  logic [WORD_W-1:0] pix_data_i,
    output logic              pix_valid_o,
    output logic [WORD_W-1:0] pix_data_o
);

    ctrl_t                       ctrl_w;
    logic                        lut_we;
    logic [IDX_W-1:0]            lut_idx;
    logic [WORD_W-1:0]           lut_wdata;
    logic [WORD_W-1:0]           lut_word;
    logic [NCH-1:0][IDX_W-1:0]   look_idx;
    logic [NCH-1:0][WORD_W-1:0]  even_word;
    logic [NCH-1:0][WORD_W-1:0]  own_word;
    logic [1:0]                  vld_q;
    logic [1:0]                  warm_q;
    logic                        en_w;

    gamma_reg_if #(
        .TOTAL_ENTRIES(TOTAL_ENTRIES),
        .BANK_ENTRIES (BANK_ENTRIES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ctrl_o     (ctrl_w),
        .lut_we_o   (lut_we),
        .lut_idx_o  (lut_idx),
        .lut_wdata_o(lut_wdata),
        .lut_word_i (lut_word)
    );

    gamma_lut_mem #(
        .DEPTH(TOTAL_ENTRIES)
    ) u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (lut_we),
        .bus_idx  (lut_idx),
        .wr_data  (lut_wdata),
        .bus_word (lut_word),
        .look_idx (look_idx),
        .even_word(even_word),
        .own_word (own_word)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        gamma_chan_pipe #(
            .IDX_W(IDX_W)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .ctrl_i    (ctrl_w),
            .pix_i     (pix_data_i[WORD_W-1-c*CH_W -: CH_W]),
            .look_idx_o(look_idx[c]),
            .even_i    (word_chan(even_word[c], c)),
            .own_i     (word_chan(own_word[c], c)),
            .pix_o     (pix_data_o[WORD_W-1-c*CH_W -: CH_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            warm_q <= '0;
        end else begin
            vld_q <= {vld_q[0], pix_valid_i};
            if (warm_q != 2'd2) begin
                warm_q <= warm_q + 2'd1;
            end
        end
    end

    assign pix_valid_o = vld_q[1];
    assign en_w        = ctrl_w.enable;

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> pix_valid_o == $past(pix_valid_i, 2));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && pix_valid_o && !$past(en_w, 2))
            |-> pix_data_o == $past(pix_data_i, 2));

endmodule

// File: tb/test_gamma_lut_stage.sv
module test_gamma_lut_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_m, rdata_s;
    logic        pix_valid_i = 1'b0;
    logic [29:0] pix_data_i = '0;
    logic        vo_m, vo_s;
    logic [29:0] po_m, po_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [29:0] m_multi  [512];
    logic [29:0] m_single [512];
    bit tb_en = 1'b0;
    bit tb_dl = 1'b0;

    logic        h_v  [2];
    logic [29:0] h_pm [2];
    logic [29:0] h_ps [2];
    string       cur_req = "R9";

    always #5 clk = ~clk;

    gamma_lut_stage #(.TOTAL_ENTRIES(512), .BANK_ENTRIES(128)) i_gamma_lut_stage (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_m), .pix_valid_i(pix_valid_i),
        .pix_data_i(pix_data_i), .pix_valid_o(vo_m), .pix_data_o(po_m));

    gamma_lut_stage i_gamma_lut_stage_single (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .pix_valid_i(pix_valid_i),
        .pix_data_i(pix_data_i), .pix_valid_o(vo_s), .pix_data_o(po_s));

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    function automatic logic [9:0] fld(input logic [29:0] w, input int c);
        return w[29-c*10 -: 10];
    endfunction

    function automatic logic [9:0] sat(input logic [9:0] a, input logic [9:0] b);
        logic [10:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[10] ? 10'h3FF : s[9:0];
    endfunction

    function automatic logic [29:0] exp_pix(input logic [29:0] p, input bit multi);
        logic [29:0] r;
        r = '0;
        for (int c = 0; c < 3; c++) begin
            logic [9:0] ch, own, ev;
            int idx;
            ch  = p[29-c*10 -: 10];
            idx = int'(ch >> 1);
            own = multi ? fld(m_multi[idx], c) : fld(m_single[idx], c);
            ev  = multi ? fld(m_multi[idx & ~1], c) : fld(m_single[idx & ~1], c);
            if (!tb_en)                r[29-c*10 -: 10] = ch;
            else if (tb_dl && idx[0])  r[29-c*10 -: 10] = sat(ev, own);
            else                       r[29-c*10 -: 10] = own;
        end
        return r;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] dm, output logic [31:0] ds);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        dm = rdata_m; ds = rdata_s;
    endtask

    task automatic set_ctrl(input bit en, input bit dl);
        logic [31:0] dm, ds;
        wr(12'h020, {30'h3FFFFFFF, dl, en});
        tb_en = en; tb_dl = dl;
        rd(12'h020, dm, ds);
        chk(dm == {30'b0, dl, en}, "R2 control readback (banked)", dm, {30'b0, dl, en});
        chk(ds == {30'b0, dl, en}, "R2 control readback (single)", ds, {30'b0, dl, en});
    endtask

    // One pixel cycle: check the result due now, then drive a new pixel.
    task automatic step(input logic v, input logic [29:0] p);
        @(negedge clk);
        chk(vo_m == h_v[1], {"R9 valid latency (banked) ", cur_req}, 32'(vo_m), 32'(h_v[1]));
        chk(vo_s == h_v[1], {"R9 valid latency (single) ", cur_req}, 32'(vo_s), 32'(h_v[1]));
        if (h_v[1]) begin
            chk(po_m == h_pm[1], {cur_req, " pixel (banked)"}, 32'(po_m), 32'(h_pm[1]));
            chk(po_s == h_ps[1], {cur_req, " pixel (single)"}, 32'(po_s), 32'(h_ps[1]));
        end
        h_v[1] = h_v[0]; h_pm[1] = h_pm[0]; h_ps[1] = h_ps[0];
        h_v[0] = v; h_pm[0] = exp_pix(p, 1'b1); h_ps[0] = exp_pix(p, 1'b0);
        pix_valid_i = v; pix_data_i = p;
    endtask

    task automatic stream(input int n);
        for (int k = 0; k < n; k++) begin
            step(($urandom % 4) != 0, 30'($urandom));
        end
        step(1'b0, '0);
        step(1'b0, '0);
        step(1'b0, '0);
    endtask

    task automatic finish_report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired before the run ended");
            finish_report();
        end
    end

    initial begin
        logic [31:0] dm, ds, w;
        void'($urandom(32'h5EED_0421));
        h_v[0] = 1'b0; h_v[1] = 1'b0;
        h_pm[0] = '0; h_pm[1] = '0; h_ps[0] = '0; h_ps[1] = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(vo_m == 1'b0 && vo_s == 1'b0, "R1 valid low after reset", 32'({vo_m, vo_s}), 32'h0);
        rd(12'h020, dm, ds); chk(dm == 0 && ds == 0, "R1 control reset", dm | ds, 32'h0);
        rd(12'h030, dm, ds); chk(dm == 0 && ds == 0, "R1 size reset", dm | ds, 32'h0);
        rd(12'h100, dm, ds); chk(dm == 0 && ds == 0, "R1 bank reset", dm | ds, 32'h0);

        // R3 size register field masking
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h030, dm, ds);
        chk(dm == 32'h1FFF_1FFF, "R3 size mask (banked)", dm, 32'h1FFF_1FFF);
        chk(ds == 32'h1FFF_1FFF, "R3 size mask (single)", ds, 32'h1FFF_1FFF);
        wr(12'h030, 32'h0123_0456);
        rd(12'h030, dm, ds);
        chk(dm == 32'h0123_0456, "R3 size value", dm, 32'h0123_0456);

        // R4 / R11 bank register
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, dm, ds);
        chk(dm == 32'h3, "R4 bank register keeps two bits", dm, 32'h3);
        chk(ds == 32'h0, "R11 single bank register ignored", ds, 32'h0);

        // Fill: banked instance through the bank register; single one sees bank ignored
        for (int b = 0; b < 4; b++) begin
            wr(12'h100, 32'(b));
            for (int i = 0; i < 128; i++) begin
                w = $urandom;
                wr(12'(12'h700 + 4 * i), w);
                m_multi[b * 128 + i] = w[29:0];
                m_single[i] = w[29:0];
            end
        end
        // Entries past the banked window: only the single-bank instance takes them (R10, R11)
        for (int i = 128; i < 512; i++) begin
            w = $urandom;
            wr(12'(12'h700 + 4 * i), w);
            m_single[i] = w[29:0];
        end
        // Directed delta entries in bank 0: base 1000, delta 100 (saturates), base 200, delta 50
        wr(12'h100, 32'h0);
        wr(12'h708, {2'b11, 10'd1000, 10'd1000, 10'd1000});
        wr(12'h70C, {2'b00, 10'd100, 10'd100, 10'd100});
        wr(12'h710, {2'b00, 10'd200, 10'd200, 10'd200});
        wr(12'h714, {2'b00, 10'd50, 10'd50, 10'd50});
        m_multi[2] = {10'd1000, 10'd1000, 10'd1000}; m_single[2] = m_multi[2];
        m_multi[3] = {10'd100, 10'd100, 10'd100};    m_single[3] = m_multi[3];
        m_multi[4] = {10'd200, 10'd200, 10'd200};    m_single[4] = m_multi[4];
        m_multi[5] = {10'd50, 10'd50, 10'd50};       m_single[5] = m_multi[5];

        // R5 raw readback per bank
        rd(12'h708, dm, ds);
        chk(dm == {2'b00, m_multi[2]}, "R5 readback top bits clear", dm, {2'b00, m_multi[2]});
        for (int k = 0; k < 8; k++) begin
            int b, i;
            b = $urandom % 4; i = $urandom % 128;
            wr(12'h100, 32'(b));
            rd(12'(12'h700 + 4 * i), dm, ds);
            chk(dm == {2'b00, m_multi[b * 128 + i]}, "R4 R5 banked readback", dm, {2'b00, m_multi[b * 128 + i]});
            chk(ds == {2'b00, m_single[i]}, "R11 R5 single readback", ds, {2'b00, m_single[i]});
        end
        // R10 unmapped offsets
        wr(12'hF00, 32'hFFFF_FFFF);
        rd(12'hF00, dm, ds);
        chk(dm == 0 && ds == 0, "R10 past window reads zero", dm | ds, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, dm, ds);
        chk(dm == 0 && ds == 0, "R10 unmapped reads zero", dm | ds, 32'h0);
        rd(12'h702, dm, ds);
        chk(dm == 0 && ds == 0, "R10 unaligned reads zero", dm | ds, 32'h0);
        rd(12'h030, dm, ds);
        chk(dm == 32'h0123_0456, "R10 unmapped write left size alone", dm, 32'h0123_0456);

        // R8 disabled, delta off and on
        set_ctrl(1'b0, 1'b0); cur_req = "R8"; stream(60);
        set_ctrl(1'b0, 1'b1); cur_req = "R8"; stream(40);

        // R6 plain lookup
        set_ctrl(1'b1, 1'b0); cur_req = "R6";
        stream(250);
        step(1'b1, {10'd0, 10'd1023, 10'd511});
        step(1'b1, {10'd6, 10'd7, 10'd255});
        stream(0);

        // R7 delta lookup, directed saturation and boundaries, then random
        set_ctrl(1'b1, 1'b1); cur_req = "R7";
        step(1'b1, {10'd6, 10'd7, 10'd4});
        step(1'b1, {10'd10, 10'd11, 10'd9});
        step(1'b1, {10'd0, 10'd3, 10'd1023});
        step(1'b1, {10'd1022, 10'd2, 10'd5});
        stream(250);

        set_ctrl(1'b0, 1'b0); cur_req = "R8"; stream(20);

        done = 1'b1;
        finish_report();
    end

endmodule